// File: doc/BRIEF.md
# Code-Race Successive-Approximation Test Controller

This block is the digital half of a static linearity test that pits two converters of the same type against each other. A sawtooth ramp drives both converters. An offset DAC word, which the block produces, is added to the reference converter's input. On every qualified sample the block sees both output codes. For every target code it records which converter got there first. After each ramp it moves that code's DAC trial one binary-search step up or down, so the ramp itself acts as the comparator.

All target codes are resolved together. Each code keeps its own trial word, and one ramp settles one bit for every code on it. A full measurement is therefore DAC_W ramps long. While a ramp runs, the DAC output shows the trial of the lowest code that is still undecided, which is the code the ramp is approaching next. The block provides two pairings. In same-code mode, code c of the reference is raced against code c of the device under test. In adjacent mode, code c of the reference is raced against code c+1 of the device under test. After the last ramp a done pulse is raised, and the final word of any code can then be read through an index port.

The sequencer has five states:
- IDLE, after reset.
- RAMP, while samples are taken.
- COMMIT, one cycle that applies the step to every code.
- ARMED, between ramps.
- FINISHED, results readable.

It has these transitions:
- IDLE→RAMP on a start pulse, which clears all trials.
- RAMP→COMMIT on an end pulse.
- COMMIT→ARMED when ramps remain.
- COMMIT→FINISHED after the last ramp.
- ARMED→RAMP on a start pulse, which keeps the trials.
- FINISHED→RAMP on a start pulse, which clears all trials and restarts the count.

Top module: `race_sar_ctrl`

## Requirements
- R1: After reset, dac_word, done and rd_word are all zero.
- R2: Within a ramp, the outcome of code c is fixed on the first qualified sample in which either converter is at or beyond its target. It is a reference win if only the reference is there, a test win if only the test converter is there, and a tie if both are there. Later samples do not change it.
- R3: When adj_mode is 1, the test converter's target for code c is c+1. The top code's test target can therefore never be reached. When adj_mode is 0, both targets are c.
- R4: At COMMIT of ramp n (n = 0 first), the step is 2^(DAC_W-1-n). A reference win or a tie adds the step to that code's trial. A test win, or no outcome at all, subtracts the step, saturating at 0.
- R5: dac_word equals the trial of the lowest-index code whose outcome in the current ramp is still open. It is 0 when every code has an outcome.
- R6: done is high for exactly one cycle: the second cycle after the cycle in which sweep_end is sampled during the DAC_W-th ramp. It is low at all other times.
- R7: rd_word shows the trial of code rd_idx while in FINISHED, and 0 in every other state.
- R8: A sweep_start in IDLE or FINISHED clears every trial to 0 and restarts the ramp count. A sweep_start in ARMED keeps the trials.
- R9: sample_valid and sweep_end have no effect outside RAMP. A trial changes only at COMMIT or on a clearing start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sweep_start | input | 1 | Pulse that begins a ramp |
| sweep_end | input | 1 | Pulse that closes the current ramp |
| sample_valid | input | 1 | Qualifies ref_code and dut_code |
| adj_mode | input | 1 | 0 = same-code race, 1 = adjacent-code race |
| ref_code | input | CODE_W | Reference converter output code |
| dut_code | input | CODE_W | Device-under-test converter output code |
| rd_idx | input | CODE_W | Code index for readout |
| dac_word | output | DAC_W | Offset DAC trial word |
| done | output | 1 | One-cycle pulse after the last ramp |
| rd_word | output | DAC_W | Final trial of code rd_idx |

## Verification
The bench builds the block with its defaults: CODE_W = 4, giving 16 codes, and DAC_W = 8, giving eight ramps. At this size every code, including the unreachable top code in adjacent mode, can be checked against a model that scans each sample. The ramps shift the test converter ahead of and behind the reference, and they cap both converters below full scale. Between them they produce reference wins, test wins, ties and codes that nobody reaches, and each of these drives its own add or saturating-subtract path. One full measurement runs in each mode. The second is started from FINISHED, which exercises the clearing restart.

// File: rtl/race_sar_pkg.sv
package race_sar_pkg;
    typedef enum logic [1:0] {
        OUT_NONE = 2'd0,
        OUT_REF  = 2'd1,
        OUT_DUT  = 2'd2,
        OUT_TIE  = 2'd3
    } race_outcome_e;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RAMP     = 3'd1,
        ST_COMMIT   = 3'd2,
        ST_ARMED    = 3'd3,
        ST_FINISHED = 3'd4
    } seq_state_e;
endpackage

// File: rtl/race_sar_seq.sv
module race_sar_seq
    import race_sar_pkg::*;
#(
    parameter int DAC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sweep_start,
    input  logic             sweep_end,
    input  logic             sample_valid,
    output logic             sample_en,
    output logic             commit,
    output logic             clear_all,
    output logic [DAC_W-1:0] step,
    output logic             finished,
    output logic             done
);
    localparam int CNT_W = (DAC_W > 1) ? $clog2(DAC_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DAC_W - 1);

    seq_state_e     state, state_nx;
    logic [CNT_W-1:0] sweep_cnt;
    logic           done_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (sweep_start) state_nx = ST_RAMP;
            ST_RAMP:     if (sweep_end)   state_nx = ST_COMMIT;
            ST_COMMIT:   state_nx = (sweep_cnt == LAST) ? ST_FINISHED : ST_ARMED;
            ST_ARMED:    if (sweep_start) state_nx = ST_RAMP;
            ST_FINISHED: if (sweep_start) state_nx = ST_RAMP;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        sample_en = (state == ST_RAMP) && sample_valid;
        commit    = (state == ST_COMMIT);
        clear_all = sweep_start && ((state == ST_IDLE) || (state == ST_FINISHED));
        finished  = (state == ST_FINISHED);
        step      = {{(DAC_W-1){1'b0}}, 1'b1} << (LAST - sweep_cnt);
        done      = done_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sweep_cnt <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= (state == ST_COMMIT) && (sweep_cnt == LAST);
            if (clear_all)
                sweep_cnt <= '0;
            else if (commit && (sweep_cnt != LAST))
                sweep_cnt <= sweep_cnt + 1'b1;
        end
    end

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(state) == ST_COMMIT);
    p_count_final_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINISHED) |-> (sweep_cnt == LAST));
    p_ramp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RAMP && !sweep_end) |=> (state == ST_RAMP));
endmodule

// File: rtl/race_sar_cell.sv
module race_sar_cell
    import race_sar_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int DAC_W  = 8,
    parameter int IDX    = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] ref_code,
    input  logic [CODE_W-1:0] dut_code,
    input  logic              adj_mode,
    input  logic              sample_en,
    input  logic              commit,
    input  logic              clear,
    input  logic [DAC_W-1:0]  step,
    output logic [DAC_W-1:0]  trial,
    output logic              undecided
);
    localparam logic [CODE_W:0] TGT_REF = (CODE_W+1)'(IDX);

    race_outcome_e     outcome;
    logic [CODE_W:0]   tgt_dut;
    logic              ref_hit, dut_hit;
    logic [DAC_W-1:0]  trial_upd;

    always_comb begin
        tgt_dut = TGT_REF + {{CODE_W{1'b0}}, adj_mode};
        ref_hit = {1'b0, ref_code} >= TGT_REF;
        dut_hit = {1'b0, dut_code} >= tgt_dut;
        if (outcome == OUT_REF || outcome == OUT_TIE)
            trial_upd = trial + step;
        else
            trial_upd = (trial >= step) ? (trial - step) : '0;
        undecided = (outcome == OUT_NONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            outcome <= OUT_NONE;
            trial   <= '0;
        end else if (commit) begin
            outcome <= OUT_NONE;
            trial   <= trial_upd;
        end else if (sample_en && outcome == OUT_NONE) begin
            if (ref_hit && dut_hit)  outcome <= OUT_TIE;
            else if (ref_hit)        outcome <= OUT_REF;
            else if (dut_hit)        outcome <= OUT_DUT;
        end
    end

    p_trial_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !clear) |=> $stable(trial));
    p_outcome_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (outcome != OUT_NONE && !commit && !clear) |=> (outcome == $past(outcome)));
    p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (trial == '0));
    p_idle_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_en && !commit && !clear) |=> $stable(outcome));
endmodule

// File: rtl/race_sar_pick.sv
module race_sar_pick #(
    parameter int NCODES = 16,
    parameter int DAC_W  = 8
) (
    input  logic [NCODES-1:0][DAC_W-1:0] trials,
    input  logic [NCODES-1:0]            undecided,
    output logic [DAC_W-1:0]             dac_word
);
    logic found;

    always_comb begin
        dac_word = '0;
        found    = 1'b0;
        for (int i = 0; i < NCODES; i++) begin
            if (!found && undecided[i]) begin
                dac_word = trials[i];
                found    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/race_sar_ctrl.sv
module race_sar_ctrl #(
    parameter int CODE_W = 4,
    parameter int DAC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sweep_start,
    input  logic              sweep_end,
    input  logic              sample_valid,
    input  logic              adj_mode,
    input  logic [CODE_W-1:0] ref_code,
    input  logic [CODE_W-1:0] dut_code,
    input  logic [CODE_W-1:0] rd_idx,
    output logic [DAC_W-1:0]  dac_word,
    output logic              done,
    output logic [DAC_W-1:0]  rd_word
);
    localparam int NCODES = 1 << CODE_W;

    logic                          sample_en, commit, clear_all, finished;
    logic [DAC_W-1:0]              step;
    logic [NCODES-1:0][DAC_W-1:0]  trials;
    logic [NCODES-1:0]             undecided;

    race_sar_seq #(.DAC_W(DAC_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .sweep_start  (sweep_start),
        .sweep_end    (sweep_end),
        .sample_valid (sample_valid),
        .sample_en    (sample_en),
        .commit       (commit),
        .clear_all    (clear_all),
        .step         (step),
        .finished     (finished),
        .done         (done)
    );

    for (genvar g = 0; g < NCODES; g++) begin : g_code
        race_sar_cell #(.CODE_W(CODE_W), .DAC_W(DAC_W), .IDX(g)) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .ref_code  (ref_code),
            .dut_code  (dut_code),
            .adj_mode  (adj_mode),
            .sample_en (sample_en),
            .commit    (commit),
            .clear     (clear_all),
            .step      (step),
            .trial     (trials[g]),
            .undecided (undecided[g])
        );
    end

    race_sar_pick #(.NCODES(NCODES), .DAC_W(DAC_W)) u_pick (
        .trials    (trials),
        .undecided (undecided),
        .dac_word  (dac_word)
    );

    always_comb rd_word = finished ? trials[rd_idx] : '0;

    p_rd_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!finished && !$past(finished)) |-> (rd_word == '0));
endmodule

// File: tb/race_sar_ctrl_bench.sv
`timescale 1ns/1ps
module race_sar_ctrl_bench;
    localparam int CODE_W = 4;
    localparam int DAC_W  = 8;
    localparam int NC     = 1 << CODE_W;

    typedef struct { int idx; int word; } rd_item_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sweep_start = 0, sweep_end = 0, sample_valid = 0, adj_mode = 0;
    logic [CODE_W-1:0] ref_code = '0, dut_code = '0, rd_idx = '0;
    logic [DAC_W-1:0]  dac_word, rd_word;
    logic              done;

    int total = 0, bad = 0;
    int exp_trial [NC];
    int exp_out   [NC];   // 0 open, 1 ref, 2 dut, 3 tie
    rd_item_t exp_q[$];
    bit mon_busy = 0;

    always #10 clk = ~clk;

    race_sar_ctrl #(.CODE_W(CODE_W), .DAC_W(DAC_W)) u_race_sar_ctrl (
        .clk(clk), .rst_n(rst_n), .sweep_start(sweep_start), .sweep_end(sweep_end),
        .sample_valid(sample_valid), .adj_mode(adj_mode), .ref_code(ref_code),
        .dut_code(dut_code), .rd_idx(rd_idx), .dac_word(dac_word), .done(done),
        .rd_word(rd_word)
    );

    task automatic chk(string req, int act, int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int exp_dac();
        for (int c = 0; c < NC; c++) if (exp_out[c] == 0) return exp_trial[c];
        return 0;
    endfunction

    // one qualified sample: drive at a falling edge, check at the next
    task automatic do_sample(int r, int d, int adj, string tag);
        ref_code = CODE_W'(r); dut_code = CODE_W'(d); sample_valid = 1;
        for (int c = 0; c < NC; c++) begin
            if (exp_out[c] == 0) begin
                bit rh = (r >= c);
                bit dh = (d >= c + adj);
                if (rh && dh) exp_out[c] = 3;
                else if (rh)  exp_out[c] = 1;
                else if (dh)  exp_out[c] = 2;
            end
        end
        @(negedge clk);
        chk(tag, dac_word, exp_dac());
    endtask

    task automatic run_sweep(int sw, int off, int rcap, int dcap, int adj, bit fresh);
        string tag = adj ? "R3 adjacent race dac" : "R2/R5 race dac";
        if (fresh) for (int c = 0; c < NC; c++) exp_trial[c] = 0;
        for (int c = 0; c < NC; c++) exp_out[c] = 0;
        sweep_start = 1;
        @(negedge clk);
        sweep_start = 0;
        chk(fresh ? "R8 clear on start" : "R5 dac at ramp start", dac_word, exp_trial[0]);
        chk("R7 rd_word zero in ramp", rd_word, 0);
        for (int t = 0; t < 2*NC + 4; t++) begin
            int r = t / 2;
            int d = (t + off < 0) ? 0 : (t + off) / 2;
            if (r > rcap) r = rcap;
            if (d > dcap) d = dcap;
            do_sample(r, d, adj, tag);
        end
        sample_valid = 0; sweep_end = 1;
        @(negedge clk);
        sweep_end = 0;
        chk("R6 done low in commit", done, 0);
        for (int c = 0; c < NC; c++) begin
            int st = (1 << (DAC_W - 1)) >> sw;
            if (exp_out[c] == 1 || exp_out[c] == 3) exp_trial[c] += st;
            else exp_trial[c] = (exp_trial[c] >= st) ? exp_trial[c] - st : 0;
            exp_out[c] = 0;
        end
        @(negedge clk);
        chk("R6 done pulse", done, (sw == DAC_W - 1) ? 1 : 0);
        chk("R4 dac after commit", dac_word, exp_trial[0]);
        @(negedge clk);
        chk("R6 done single cycle", done, 0);
    endtask

    task automatic push_results(string req);
        for (int c = 0; c < NC; c++) begin
            rd_item_t it;
            it.idx = c; it.word = exp_trial[c];
            exp_q.push_back(it);
        end
        wait (exp_q.size() == 0);
        wait (mon_busy == 0);
        @(negedge clk);
        $display("readout %s done", req);
    endtask

    // monitor: pops expected words and compares the readout port
    initial begin
        forever begin
            rd_item_t it;
            wait (exp_q.size() != 0);
            mon_busy = 1;
            it = exp_q.pop_front();
            @(negedge clk);
            rd_idx = CODE_W'(it.idx);
            @(negedge clk);
            chk("R4/R7 final word", rd_word, it.word);
            mon_busy = 0;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int offs_a [DAC_W] = '{1, -1, 0, 2, -3, 1, -1, 0};
        int offs_b [DAC_W] = '{0, 2, -1, 1, -2, 3, 0, -1};
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset dac", dac_word, 0);
        chk("R1 reset done", done, 0);
        chk("R1 reset rd_word", rd_word, 0);

        // same-code measurement
        adj_mode = 0;
        for (int s = 0; s < DAC_W; s++) begin
            bit capped = (s == 4);
            run_sweep(s, offs_a[s], capped ? 13 : NC-1, capped ? 12 : NC-1, 0, s == 0);
            if (s == 2) begin
                // stray strobes while armed must change nothing
                ref_code = '1; dut_code = '1; sample_valid = 1; sweep_end = 1;
                @(negedge clk);
                sample_valid = 0; sweep_end = 0;
                @(negedge clk);
                chk("R9 strobes ignored when armed", dac_word, exp_trial[0]);
                chk("R9 trial kept", dac_word, exp_trial[0]);
            end
        end
        push_results("same-code");

        // adjacent-code measurement, restarted from FINISHED
        adj_mode = 1;
        for (int s = 0; s < DAC_W; s++)
            run_sweep(s, offs_b[s], NC-1, NC-1, 1, s == 0);
        push_results("R3 adjacent");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule